// File: doc/BRIEF.md
# Per-Chip Pattern Column Translator Array

This block models the column-address path of a rank of eight memory chips that all listen to one shared command/address bus. Each chip holds a small translator that knows its own fixed chip number. When a READ or WRITE arrives, the command also carries a 3-bit pattern code. The translator folds the pattern into the low column bits as `column XOR (pattern AND chip number)`. Chips that see the same bus address can therefore open different columns, and a single command collects or distributes a power-of-two strided set of words. The cost in each chip is one AND and one XOR.

Every other command leaves the address alone. The wrapper places eight translators beside eight per-chip word stores. It also holds the column-dependent word placement that a memory controller would apply: word `w` of the line at column `c` lives in chip `w XOR (c mod 8)`. The wrapper then reorders the words that come back into ascending element order. Writes are spread over the chips in the same order, so a strided write puts each word where a strided read will find it.

Pattern 0 reads or writes one ordinary line (stride 1). Patterns 1, 3 and 7 collect every 2nd, 4th and 8th element of the region starting at the addressed column.

Top module: `gs_column_array`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `col_vld` and `rd_vld` are 0.
- R2: A strobe (`cmd_vld`=1) carrying READ (code 2) or WRITE (code 3) makes `col_vld` pulse high for exactly the next cycle. In that cycle, chip k's field `chip_col[k*COL_W +: COL_W]` equals the strobed address XOR (pattern AND k), where k and the pattern are 3-bit values. Address bits above bit 2 pass through unchanged.
- R3: A strobe with any other code (NOP 0, ACTIVATE 1, PRECHARGE 4, REFRESH 5) also pulses `col_vld` one cycle later, and every chip field equals the strobed address unchanged.
- R4: With pattern 0 all eight chip columns are equal. A read of column c then returns the line of elements 8c..8c+7, with element 8c+j in byte slot j of `rd_line` (bits `[j*WORD_W +: WORD_W]`).
- R5: A WRITE with pattern p at column a stores byte slot j of `wr_line` into the j-th smallest element of the gathered set for (a, p). Element 8c+w is the one that chip `w XOR (c mod 8)` reads at column c. A READ with the same (a, p) returns those bytes in the same slots.
- R6: Once element e holds value e, a READ of column 0 with pattern 1 returns 0, 2, 4, ..., 14 in slots 0..7.
- R7: With the same contents, a READ of column 0 returns 0, 4, ..., 28 with pattern 3, and 0, 8, ..., 56 with pattern 7.
- R8: `rd_vld` pulses for one cycle exactly two cycles after a READ strobe and never after any other command.
- R9: Commands other than WRITE never change stored data, whatever `wr_line` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | One-cycle command strobe |
| cmd | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH |
| col_addr | input | COL_W | Shared column address |
| patt | input | 3 | Pattern code sent with the command |
| wr_line | input | 8*WORD_W | Write data, slot j in bits [j*WORD_W +: WORD_W] |
| col_vld | output | 1 | Translated columns valid (one cycle after strobe) |
| chip_col | output | 8*COL_W | Translated column of chip k in bits [k*COL_W +: COL_W] |
| rd_vld | output | 1 | Read line valid (two cycles after a READ strobe) |
| rd_line | output | 8*WORD_W | Gathered read data in ascending element order |

## Verification
The assertions assume that `cmd`, `col_addr` and `patt` matter only in a cycle where `cmd_vld` is high. They also assume `cmd_vld` is low throughout reset, because the column checks compare against the previous cycle's inputs. The stimulus drives each strobe for a single cycle on the falling edge and idles the inputs between strobes. Reads are issued only after every column has been written once, so no expected value depends on uninitialised storage. Random operations draw any pattern code 0..7 and all six command codes, so non-power-of-two patterns are also covered as ordinary permutations.

// File: rtl/gs_col_pkg.sv
package gs_col_pkg;
  localparam int CHIP_BITS = 3;
  localparam int NCHIP     = 1 << CHIP_BITS;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  // Commands that carry a pattern and use a translated column
  function automatic logic is_access(input logic [2:0] c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  // Low column bits seen by one chip
  function automatic logic [CHIP_BITS-1:0] low_xlate(
    input logic [CHIP_BITS-1:0] addr_low,
    input logic [CHIP_BITS-1:0] patt,
    input logic [CHIP_BITS-1:0] chip_id);
    return addr_low ^ (patt & chip_id);
  endfunction

  // Word-in-line held by a chip at a given column (column-dependent placement)
  function automatic logic [CHIP_BITS-1:0] word_of(
    input logic [CHIP_BITS-1:0] chip_id,
    input logic [CHIP_BITS-1:0] col_low);
    return chip_id ^ col_low;
  endfunction
endpackage

// File: rtl/gs_col_xlate.sv
module gs_col_xlate
  import gs_col_pkg::*;
#(
  parameter int COL_W   = 5,
  parameter int CHIP_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [2:0]       cmd,
  input  logic [COL_W-1:0] col_in,
  input  logic [2:0]       patt,
  output logic [COL_W-1:0] col_out
);
  localparam logic [CHIP_BITS-1:0] ID_V = CHIP_BITS'(CHIP_ID);

  logic             xl_hit;
  logic [COL_W-1:0] xl_col;

  assign xl_hit = is_access(cmd);

  always_comb begin
    xl_col = col_in;
    xl_col[CHIP_BITS-1:0] = low_xlate(col_in[CHIP_BITS-1:0], patt, ID_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_out <= '0;
    end else if (cmd_vld) begin
      col_out <= xl_hit ? xl_col : col_in;
    end
  end
endmodule

// File: rtl/gs_col_bank.sv
module gs_col_bank #(
  parameter int COL_W  = 5,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int NCOL = 1 << COL_W;

  logic [WORD_W-1:0] mem [NCOL];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/gs_col_order.sv
module gs_col_order
  import gs_col_pkg::*;
#(
  parameter int COL_W = 5
) (
  input  logic [NCHIP*COL_W-1:0]     cols,
  output logic [NCHIP*CHIP_BITS-1:0] slots,
  output logic [NCHIP-1:0]           slot_seen
);
  localparam int TAG_W = COL_W + CHIP_BITS;

  logic [TAG_W-1:0]     tag [NCHIP];
  logic [CHIP_BITS-1:0] cnt;

  // Element index held by each chip: column * 8 + word-in-line
  always_comb begin
    for (int k = 0; k < NCHIP; k++) begin
      tag[k] = {cols[k*COL_W +: COL_W],
                word_of(CHIP_BITS'(k), cols[k*COL_W +: CHIP_BITS])};
    end
  end

  // Rank of each chip's element among the eight
  always_comb begin
    slots     = '0;
    slot_seen = '0;
    cnt       = '0;
    for (int k = 0; k < NCHIP; k++) begin
      cnt = '0;
      for (int j = 0; j < NCHIP; j++) begin
        cnt = cnt + CHIP_BITS'(tag[j] < tag[k]);
      end
      slots[k*CHIP_BITS +: CHIP_BITS] = cnt;
      slot_seen[cnt] = 1'b1;
    end
  end
endmodule

// File: rtl/gs_column_array.sv
module gs_column_array
  import gs_col_pkg::*;
#(
  parameter int COL_W  = 5,
  parameter int WORD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_vld,
  input  logic [2:0]              cmd,
  input  logic [COL_W-1:0]        col_addr,
  input  logic [2:0]              patt,
  input  logic [NCHIP*WORD_W-1:0] wr_line,
  output logic                    col_vld,
  output logic [NCHIP*COL_W-1:0]  chip_col,
  output logic                    rd_vld,
  output logic [NCHIP*WORD_W-1:0] rd_line
);
  logic [2:0]                 cmd_q;
  logic [NCHIP*WORD_W-1:0]    wr_q;
  logic [NCHIP*CHIP_BITS-1:0] slots;
  logic [NCHIP-1:0]           slot_seen;
  logic [CHIP_BITS-1:0]       slot_a  [NCHIP];
  logic [WORD_W-1:0]          rd_word [NCHIP];
  logic [NCHIP*WORD_W-1:0]    rd_next;
  logic                       do_wr;
  logic                       do_rd;

  // Stage 1: command registers beside the per-chip translators
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_vld <= 1'b0;
      cmd_q   <= CMD_NOP;
      wr_q    <= '0;
    end else begin
      col_vld <= cmd_vld;
      if (cmd_vld) begin
        cmd_q <= cmd;
        wr_q  <= wr_line;
      end
    end
  end

  assign do_wr = col_vld && (cmd_q == CMD_WR);
  assign do_rd = col_vld && (cmd_q == CMD_RD);

  gs_col_order #(.COL_W(COL_W)) u_order (
    .cols      (chip_col),
    .slots     (slots),
    .slot_seen (slot_seen)
  );

  for (genvar g = 0; g < NCHIP; g++) begin : g_chip
    gs_col_xlate #(.COL_W(COL_W), .CHIP_ID(g)) u_xl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_vld (cmd_vld),
      .cmd     (cmd),
      .col_in  (col_addr),
      .patt    (patt),
      .col_out (chip_col[g*COL_W +: COL_W])
    );

    assign slot_a[g] = slots[g*CHIP_BITS +: CHIP_BITS];

    gs_col_bank #(.COL_W(COL_W), .WORD_W(WORD_W)) u_bank (
      .clk   (clk),
      .wr_en (do_wr),
      .addr  (chip_col[g*COL_W +: COL_W]),
      .wdata (wr_q[slot_a[g]*WORD_W +: WORD_W]),
      .rdata (rd_word[g])
    );
  end

  // Put each chip's word back in ascending element order
  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NCHIP; k++) begin
      rd_next[slot_a[k]*WORD_W +: WORD_W] = rd_word[k];
    end
  end

  // Stage 2: gathered read data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_line <= '0;
    end else begin
      rd_vld <= do_rd;
      if (do_rd) rd_line <= rd_next;
    end
  end
endmodule

// File: rtl/gs_column_array_chk.sv
module gs_column_array_chk
  import gs_col_pkg::*;
#(
  parameter int COL_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_vld,
  input logic [2:0]             cmd,
  input logic [COL_W-1:0]       col_addr,
  input logic [2:0]             patt,
  input logic                   col_vld,
  input logic [NCHIP*COL_W-1:0] chip_col,
  input logic                   rd_vld,
  input logic [NCHIP-1:0]       slot_seen
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!col_vld && !rd_vld)); // R1

  AST_VLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> col_vld); // R2

  AST_VLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !col_vld); // R2

  for (genvar k = 0; k < NCHIP; k++) begin : g_k
    AST_XLATE_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld && $past(cmd_vld) && is_access($past(cmd)))
      |-> chip_col[k*COL_W +: COL_W] ==
          ($past(col_addr) ^ COL_W'($past(patt) & CHIP_BITS'(k)))); // R2

    AST_PASS_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld && $past(cmd_vld) && !is_access($past(cmd)))
      |-> chip_col[k*COL_W +: COL_W] == $past(col_addr)); // R3

    AST_PATT0_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld && $past(patt) == 3'd0)
      |-> chip_col[k*COL_W +: COL_W] == chip_col[COL_W-1:0]); // R4
  end

  AST_SLOT_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld |-> $countones(slot_seen) == NCHIP); // R5

  AST_RD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> ($past(col_vld) && $past(cmd_vld, 2) && $past(cmd, 2) == CMD_RD)); // R8
endmodule

bind gs_column_array gs_column_array_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_vld   (cmd_vld),
  .cmd       (cmd),
  .col_addr  (col_addr),
  .patt      (patt),
  .col_vld   (col_vld),
  .chip_col  (chip_col),
  .rd_vld    (rd_vld),
  .slot_seen (slot_seen)
);

// File: tb/sim_gs_column_array.sv
module sim_gs_column_array;
  localparam int COL_W  = 5;
  localparam int WORD_W = 8;
  localparam int NC     = 8;
  localparam int NCOL   = 1 << COL_W;
  localparam int NEL    = NCOL * NC;
  localparam int EW     = COL_W + 3;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cmd_vld = 1'b0;
  logic [2:0]           cmd = 3'd0;
  logic [COL_W-1:0]     col_addr = '0;
  logic [2:0]           patt = 3'd0;
  logic [NC*WORD_W-1:0] wr_line = '0;
  logic                 col_vld;
  logic [NC*COL_W-1:0]  chip_col;
  logic                 rd_vld;
  logic [NC*WORD_W-1:0] rd_line;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [WORD_W-1:0] model [NEL];

  always #10 clk = ~clk;

  gs_column_array #(.COL_W(COL_W), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd),
    .col_addr(col_addr), .patt(patt), .wr_line(wr_line),
    .col_vld(col_vld), .chip_col(chip_col), .rd_vld(rd_vld), .rd_line(rd_line)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Sorted element indices reached by (address, pattern)
  function automatic logic [NC*EW-1:0] gather_set(input logic [COL_W-1:0] a,
                                                 input logic [2:0] p);
    int e [NC];
    int t;
    logic [NC*EW-1:0] r;
    for (int k = 0; k < NC; k++) begin
      int c;
      c = int'(a) ^ (int'(p) & k);
      e[k] = c * NC + ((c % NC) ^ k);
    end
    for (int i = 0; i < NC; i++) begin
      for (int j = 0; j < NC - 1 - i; j++) begin
        if (e[j] > e[j+1]) begin
          t = e[j]; e[j] = e[j+1]; e[j+1] = t;
        end
      end
    end
    r = '0;
    for (int j = 0; j < NC; j++) r[j*EW +: EW] = EW'(e[j]);
    return r;
  endfunction

  function automatic logic [NC*WORD_W-1:0] model_line(input logic [NC*EW-1:0] s);
    logic [NC*WORD_W-1:0] r;
    for (int j = 0; j < NC; j++) r[j*WORD_W +: WORD_W] = model[s[j*EW +: EW]];
    return r;
  endfunction

  task automatic issue(input logic [2:0] c, input logic [COL_W-1:0] a,
                       input logic [2:0] p, input logic [NC*WORD_W-1:0] line,
                       input string rtag);
    logic [NC*EW-1:0] s;
    bit acc;
    acc = (c == 3'd2) || (c == 3'd3);
    s = gather_set(a, p);
    @(negedge clk);
    cmd_vld = 1'b1; cmd = c; col_addr = a; patt = p; wr_line = line;
    @(negedge clk);
    cmd_vld = 1'b0; cmd = 3'd0; wr_line = '0;
    chk(col_vld === 1'b1, "R2", "col_vld one cycle after strobe", 64'(col_vld), 64'd1);
    for (int k = 0; k < NC; k++) begin
      logic [COL_W-1:0] ex;
      ex = acc ? (a ^ COL_W'(p & 3'(k))) : a;
      chk(chip_col[k*COL_W +: COL_W] === ex, acc ? "R2" : "R3", "chip column",
          64'(chip_col[k*COL_W +: COL_W]), 64'(ex));
    end
    chk(rd_vld === 1'b0, "R8", "rd_vld not yet", 64'(rd_vld), 64'd0);
    @(negedge clk);
    chk(col_vld === 1'b0, "R2", "col_vld single pulse", 64'(col_vld), 64'd0);
    if (c == 3'd2) begin
      chk(rd_vld === 1'b1, "R8", "rd_vld after READ", 64'(rd_vld), 64'd1);
      chk(rd_line === model_line(s), rtag, "gathered line", rd_line, model_line(s));
    end else begin
      chk(rd_vld === 1'b0, "R8", "no rd_vld for non-READ", 64'(rd_vld), 64'd0);
    end
    if (c == 3'd3) begin
      for (int j = 0; j < NC; j++) model[s[j*EW +: EW]] = line[j*WORD_W +: WORD_W];
    end
  endtask

  initial begin
    logic [NC*WORD_W-1:0] ln;
    logic [NC*WORD_W-1:0] exp_l;
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(col_vld === 1'b0 && rd_vld === 1'b0, "R1", "idle in reset",
        64'({col_vld, rd_vld}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_vld === 1'b0 && rd_vld === 1'b0, "R1", "idle after reset",
        64'({col_vld, rd_vld}), 64'd0);

    // Preload: element e holds value e (pattern 0 writes)
    for (int c = 0; c < NCOL; c++) begin
      for (int w = 0; w < NC; w++) ln[w*WORD_W +: WORD_W] = WORD_W'(c*NC + w);
      issue(3'd3, COL_W'(c), 3'd0, ln, "R5");
    end

    // R6: stride 2 from column 0
    issue(3'd2, '0, 3'd1, '0, "R6");
    for (int j = 0; j < NC; j++) exp_l[j*WORD_W +: WORD_W] = WORD_W'(2*j);
    chk(rd_line === exp_l, "R6", "stride-2 gather 0..14", rd_line, exp_l);
    // R7: strides 4 and 8
    issue(3'd2, '0, 3'd3, '0, "R7");
    for (int j = 0; j < NC; j++) exp_l[j*WORD_W +: WORD_W] = WORD_W'(4*j);
    chk(rd_line === exp_l, "R7", "stride-4 gather", rd_line, exp_l);
    issue(3'd2, '0, 3'd7, '0, "R7");
    for (int j = 0; j < NC; j++) exp_l[j*WORD_W +: WORD_W] = WORD_W'(8*j);
    chk(rd_line === exp_l, "R7", "stride-8 gather", rd_line, exp_l);
    // R4: plain line read
    issue(3'd2, COL_W'(5), 3'd0, '0, "R4");
    for (int j = 0; j < NC; j++) exp_l[j*WORD_W +: WORD_W] = WORD_W'(40 + j);
    chk(rd_line === exp_l, "R4", "stride-1 line at column 5", rd_line, exp_l);

    // R9: non-write commands with data on the bus leave storage untouched
    issue(3'd1, COL_W'(9), 3'd1, {NC{8'hA5}}, "R9");
    issue(3'd5, COL_W'(9), 3'd0, {NC{8'h5A}}, "R9");
    issue(3'd4, COL_W'(9), 3'd7, {NC{8'hFF}}, "R9");
    issue(3'd0, COL_W'(9), 3'd3, {NC{8'h3C}}, "R9");
    issue(3'd2, COL_W'(9), 3'd0, '0, "R9");
    for (int j = 0; j < NC; j++) exp_l[j*WORD_W +: WORD_W] = WORD_W'(72 + j);
    chk(rd_line === exp_l, "R9", "column 9 unchanged", rd_line, exp_l);

    // R5: strided scatter then strided gather
    ln = 64'h0123_4567_89AB_CDEF;
    issue(3'd3, COL_W'(18), 3'd1, ln, "R5");
    issue(3'd2, COL_W'(18), 3'd1, '0, "R5");
    chk(rd_line === ln, "R5", "scatter/gather round trip", rd_line, ln);
    issue(3'd2, COL_W'(18), 3'd0, '0, "R5");
    issue(3'd2, COL_W'(19), 3'd0, '0, "R5");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      logic [2:0] c;
      r = $urandom % 10;
      if (r < 4) c = 3'd2;
      else if (r < 7) c = 3'd3;
      else begin
        case ($urandom % 4)
          0: c = 3'd0;
          1: c = 3'd1;
          2: c = 3'd4;
          default: c = 3'd5;
        endcase
      end
      ln = {$urandom, $urandom};
      issue(c, COL_W'($urandom), 3'($urandom), ln, (c == 3'd2) ? "R5" : "R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule